// File: doc/BRIEF.md
# Charging-Port Mode and Discharge Sequencer

This block is the digital control core of a USB charging port. It takes three charge-mode control pins, a current-limit select pin, a port enable and a power-on reset. From these it picks the charging mode the port presents, and it drives the enables for the VBUS power switch and the USB 2.0 data-line switch, the VBUS discharge drive and the current-limit select. Moving between most charging modes requires the attached device to renegotiate its current. So the block turns the power switch off, drains VBUS for a fixed number of millisecond ticks, and only then enables the new mode. A change between the two host-connected modes that differ only in the limit pin skips the drain.

The pins are synchronised and must hold a new code for a set number of millisecond ticks before the block accepts it. When a low- or full-speed human-interface device is attached to a host-connected port, the block ignores a request to move to automatic dedicated-charging mode through control code 011. The data path then stays connected, so the device can still wake the system. The analog switches, the discharge resistor and the device-speed detector are outside the block.

Top module: `chgport_seq`

## Requirements
- R1: While `por_i` is high, and for the clock after it, the outputs read mode 0, power switch off, data switch off and discharge on. After `por_i` falls, the block drains VBUS for one full discharge window and then enters the mode the pins select.
- R2: With control pins written {ctl_i[2], ctl_i[1], ctl_i[0]} and then `ilim_sel_i`, the mode code on `mode_o` is as follows. 000x gives 0 (off). 001x and 011x give 1 (automatic dedicated charging). 100x gives 2 (forced shorted). 101x gives 3 (forced divider). 110x and 010x give 4 (host port, discharge on entry). 1110 gives 5 (host port, no discharge to or from mode 6). 1111 gives 6 (charging host port).
- R3: A change between two different nonzero modes turns the power switch off and asserts discharge for exactly DISCH_TICKS millisecond ticks. During that window `mode_o` reads 0.
- R4: A change between mode 5 and mode 6, in either direction, takes place with no discharge and no drop of the power switch.
- R5: A pin change that keeps the same mode (a different `ilim_sel_i` in mode 4, or 011x versus 001x) causes no discharge.
- R6: `data_sw_en_o` is high only in modes 4, 5 and 6 with the power switch on. It is low in modes 1 to 3, while off, and while discharging.
- R7: With `hid_present_i` high in mode 4, 5 or 6, control code 011 is ignored: the mode and the data switch stay as they are. Code 001 is still obeyed. When `hid_present_i` falls, the pending move to mode 1 goes ahead with a discharge.
- R8: `ilim_hi_o` follows the accepted `ilim_sel_i`, except in mode 1. There, with LOAD_DETECT = 0, it is forced high.
- R9: A pin code that holds for fewer than STABLE_TICKS ticks is ignored. The mode stays unchanged and no discharge occurs.
- R10: `en_i` low turns off the power and data switches and asserts discharge within three clocks, with mode 0. When `en_i` rises again, a full discharge window runs before the selected mode comes back.
- R11: Code 000x holds the port off with discharge asserted for as long as the code is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_ms_i | input | 1 | One-clock pulse each millisecond |
| ctl_i | input | 3 | Charge-mode control pins, bit 2 is the first pin |
| ilim_sel_i | input | 1 | Current-limit select pin |
| en_i | input | 1 | Port enable |
| por_i | input | 1 | Power-on reset, synchronous level |
| hid_present_i | input | 1 | Low/full-speed human-interface device attached |
| mode_o | output | 3 | Active charging mode code |
| data_sw_en_o | output | 1 | Data-line switch enable |
| pwr_sw_en_o | output | 1 | VBUS power switch enable |
| discharge_o | output | 1 | VBUS discharge drive |
| ilim_hi_o | output | 1 | High current-limit select |

## Verification
The bench builds the block with DISCH_TICKS = 6, STABLE_TICKS = 4, LOAD_DETECT = 0 and a tick every fourth clock. A full discharge window therefore lasts only 21 to 24 clocks. Every transition class, every HID override case and the glitch filter fit in a few thousand cycles, and the measured window separates a correct length from one that is a tick too long or too short. LOAD_DETECT = 0 exposes the forced high limit in automatic mode.

// File: rtl/chgport_pkg.sv
package chgport_pkg;

  typedef enum logic [2:0] {
    MD_OFF   = 3'd0,
    MD_AUTO  = 3'd1,
    MD_SHORT = 3'd2,
    MD_DIV1  = 3'd3,
    MD_SDP1  = 3'd4,
    MD_SDP2  = 3'd5,
    MD_CDP   = 3'd6
  } mode_e;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_ON    = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic [2:0] ctl;
    logic       ilim;
  } pins_t;

  localparam int PIN_W = $bits(pins_t);

  function automatic mode_e decode_pins(pins_t p);
    mode_e m;
    case (p.ctl)
      3'b000:         m = MD_OFF;
      3'b001, 3'b011: m = MD_AUTO;
      3'b100:         m = MD_SHORT;
      3'b101:         m = MD_DIV1;
      3'b010, 3'b110: m = MD_SDP1;
      3'b111:         m = p.ilim ? MD_CDP : MD_SDP2;
      default:        m = MD_OFF;
    endcase
    return m;
  endfunction

  function automatic logic is_data_mode(mode_e m);
    return (m == MD_SDP1) || (m == MD_SDP2) || (m == MD_CDP);
  endfunction

  function automatic logic is_quiet_pair(mode_e a, mode_e b);
    return ((a == MD_SDP2) && (b == MD_CDP)) || ((a == MD_CDP) && (b == MD_SDP2));
  endfunction

endpackage

// File: rtl/chgport_sync.sv
module chgport_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= '0;
        else       stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= '0;
        else       stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/chgport_pin_filter.sv
module chgport_pin_filter #(
  parameter int W            = 4,
  parameter int STABLE_TICKS = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         tick_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  localparam int CW = $clog2(STABLE_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(STABLE_TICKS);

  logic [W-1:0]  cand_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  acc_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cand_q <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (d_i != cand_q) begin
      cand_q <= d_i;
      cnt_q  <= '0;
    end else if (cnt_q != FULL) begin
      if (tick_i) cnt_q <= cnt_q + 1'b1;
    end else begin
      acc_q <= cand_q;
    end
  end

  assign q_o = acc_q;

endmodule

// File: rtl/chgport_drain_timer.sv
module chgport_drain_timer #(
  parameter int TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i)  cnt_q <= '0;
    else if (tick_i)      cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && tick_i && (cnt_q == LAST);

endmodule

// File: rtl/chgport_seq.sv
module chgport_seq
  import chgport_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STABLE_TICKS = 4,
  parameter int DISCH_TICKS  = 2000,
  parameter bit LOAD_DETECT  = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       tick_ms_i,
  input  logic [2:0] ctl_i,
  input  logic       ilim_sel_i,
  input  logic       en_i,
  input  logic       por_i,
  input  logic       hid_present_i,
  output logic [2:0] mode_o,
  output logic       data_sw_en_o,
  output logic       pwr_sw_en_o,
  output logic       discharge_o,
  output logic       ilim_hi_o
);

  localparam int SW = PIN_W + 2;

  logic [SW-1:0] raw_in, sync_out;
  pins_t         pins_s, pins_acc;
  logic          en_s, hid_s;
  logic          drain_done;

  assign raw_in = {ctl_i, ilim_sel_i, en_i, hid_present_i};

  chgport_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign pins_s = pins_t'(sync_out[SW-1:2]);
  assign en_s   = sync_out[1];
  assign hid_s  = sync_out[0];

  chgport_pin_filter #(.W(PIN_W), .STABLE_TICKS(STABLE_TICKS)) u_filt (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_i (tick_ms_i),
    .d_i    (pins_s),
    .q_o    (pins_acc)
  );

  seq_st_e st_q, st_n;
  mode_e   mode_q, mode_n, tgt, eff;

  chgport_drain_timer #(.TICKS(DISCH_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (st_q == ST_DRAIN),
    .tick_i (tick_ms_i),
    .done_o (drain_done)
  );

  always_comb begin
    tgt  = decode_pins(pins_acc);
    eff  = tgt;
    if (hid_s && (pins_acc.ctl == 3'b011) && is_data_mode(mode_q)) eff = mode_q;
    st_n   = st_q;
    mode_n = mode_q;
    if (por_i || !en_s) begin
      st_n   = ST_HOLD;
      mode_n = MD_OFF;
    end else begin
      case (st_q)
        ST_HOLD: begin
          if (tgt != MD_OFF) st_n = ST_DRAIN;
        end
        ST_DRAIN: begin
          if (tgt == MD_OFF) begin
            st_n = ST_HOLD;
          end else if (drain_done) begin
            st_n   = ST_ON;
            mode_n = tgt;
          end
        end
        ST_ON: begin
          if (eff != mode_q) begin
            if (eff == MD_OFF) begin
              st_n   = ST_HOLD;
              mode_n = MD_OFF;
            end else if (is_quiet_pair(mode_q, eff)) begin
              mode_n = eff;
            end else begin
              st_n   = ST_DRAIN;
              mode_n = MD_OFF;
            end
          end
        end
        default: begin
          st_n   = ST_HOLD;
          mode_n = MD_OFF;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q         <= ST_HOLD;
      mode_q       <= MD_OFF;
      mode_o       <= 3'd0;
      pwr_sw_en_o  <= 1'b0;
      discharge_o  <= 1'b1;
      data_sw_en_o <= 1'b0;
      ilim_hi_o    <= 1'b0;
    end else begin
      st_q         <= st_n;
      mode_q       <= mode_n;
      mode_o       <= mode_n;
      pwr_sw_en_o  <= (st_n == ST_ON);
      discharge_o  <= (st_n != ST_ON);
      data_sw_en_o <= (st_n == ST_ON) && is_data_mode(mode_n);
      ilim_hi_o    <= (!LOAD_DETECT && (mode_n == MD_AUTO)) ? 1'b1 : pins_acc.ilim;
    end
  end

endmodule

// File: rtl/chgport_seq_chk.sv
module chgport_seq_chk #(
  parameter int DISCH_TICKS = 2000,
  parameter bit LOAD_DETECT = 1'b0
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       tick_ms_i,
  input logic       en_i,
  input logic       por_i,
  input logic [2:0] mode_o,
  input logic       data_sw_en_o,
  input logic       pwr_sw_en_o,
  input logic       discharge_o,
  input logic       ilim_hi_o
);

  localparam int CW = $clog2(DISCH_TICKS + 2);
  localparam logic [CW-1:0] SAT = CW'(DISCH_TICKS + 1);
  localparam logic [CW-1:0] NEED = CW'(DISCH_TICKS);

  logic [CW-1:0] dis_ticks_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !discharge_o)                 dis_ticks_q <= '0;
    else if (tick_ms_i && dis_ticks_q != SAT)  dis_ticks_q <= dis_ticks_q + 1'b1;
  end

  AST_POR_FORCES_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
    por_i |=> (mode_o == 3'd0) && !pwr_sw_en_o && discharge_o && !data_sw_en_o); // R1

  AST_DRAIN_FULL_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pwr_sw_en_o) |-> (dis_ticks_q >= NEED)); // R3

  AST_DIRECT_ONLY_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    ((mode_o != $past(mode_o)) && (mode_o != 3'd0) && ($past(mode_o) != 3'd0))
      |-> (((mode_o == 3'd5) && ($past(mode_o) == 3'd6)) ||
           ((mode_o == 3'd6) && ($past(mode_o) == 3'd5)))); // R4

  AST_DATA_HOST_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
    data_sw_en_o |-> pwr_sw_en_o && !discharge_o && (mode_o >= 3'd4) && (mode_o <= 3'd6)); // R6

  AST_AUTO_HIGH_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
    (!LOAD_DETECT && (mode_o == 3'd1)) |-> ilim_hi_o); // R8

  AST_EN_LOW_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i && $past(!en_i) && $past(!en_i, 2) && $past(!en_i, 3))
      |-> !pwr_sw_en_o && discharge_o && !data_sw_en_o); // R10

endmodule

bind chgport_seq chgport_seq_chk #(
  .DISCH_TICKS (DISCH_TICKS),
  .LOAD_DETECT (LOAD_DETECT)
) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .tick_ms_i    (tick_ms_i),
  .en_i         (en_i),
  .por_i        (por_i),
  .mode_o       (mode_o),
  .data_sw_en_o (data_sw_en_o),
  .pwr_sw_en_o  (pwr_sw_en_o),
  .discharge_o  (discharge_o),
  .ilim_hi_o    (ilim_hi_o)
);

// File: tb/chgport_seq_tb_top.sv
module chgport_seq_tb_top;

  localparam int STABLE = 4;
  localparam int DISCH  = 6;
  localparam int SETTLE = 160;
  localparam int NVEC   = 18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic [2:0] ctl = 3'b000;
  logic       ilim = 1'b0;
  logic       en = 1'b1;
  logic       por = 1'b1;
  logic       hid = 1'b0;
  logic [2:0] mode;
  logic       dsw, psw, dis, lim;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  chgport_seq #(
    .SYNC_STAGES  (2),
    .STABLE_TICKS (STABLE),
    .DISCH_TICKS  (DISCH),
    .LOAD_DETECT  (1'b0)
  ) dut_i (
    .clk_i         (clk),
    .rst_i         (rst),
    .tick_ms_i     (tick),
    .ctl_i         (ctl),
    .ilim_sel_i    (ilim),
    .en_i          (en),
    .por_i         (por),
    .hid_present_i (hid),
    .mode_o        (mode),
    .data_sw_en_o  (dsw),
    .pwr_sw_en_o   (psw),
    .discharge_o   (dis),
    .ilim_hi_o     (lim)
  );

  // {ctl[2:0], ilim, hid, exp_mode[2:0], exp_data, exp_ilim, exp_disch_seen}
  localparam logic [10:0] VEC [NVEC] = '{
    {3'b000, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1},  // R11 R2 off
    {3'b111, 1'b1, 1'b0, 3'd6, 1'b1, 1'b1, 1'b1},  // R2 R3 R6 CDP
    {3'b111, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0, 1'b0},  // R4 CDP->SDP2
    {3'b111, 1'b1, 1'b0, 3'd6, 1'b1, 1'b1, 1'b0},  // R4 SDP2->CDP
    {3'b110, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, 1'b1},  // R3 R2 SDP1
    {3'b010, 1'b1, 1'b0, 3'd4, 1'b1, 1'b1, 1'b0},  // R5 same mode
    {3'b100, 1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1},  // R2 R6 shorted
    {3'b101, 1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1},  // R2 R6 divider
    {3'b011, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1},  // R8 auto forced
    {3'b001, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0},  // R5 auto alt code
    {3'b111, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1},  // R3 SDP2
    {3'b011, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0},  // R7 override
    {3'b001, 1'b0, 1'b1, 3'd1, 1'b0, 1'b1, 1'b1},  // R7 001 obeyed
    {3'b110, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0, 1'b1},  // R3 SDP1
    {3'b011, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0, 1'b0},  // R7 override
    {3'b011, 1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 1'b1},  // R7 release
    {3'b111, 1'b1, 1'b0, 3'd6, 1'b1, 1'b1, 1'b1},  // R3 CDP
    {3'b000, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1}   // R11 off
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic settle(input int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dis) seen = 1'b1;
    end
  endtask

  function automatic logic [6:0] pack_out(logic [2:0] m, logic d, logic l, logic s, logic p);
    return {m, d, l, s, p};
  endfunction

  initial begin
    bit seen;
    int hi;
    bit inwin;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset/POR state
    check(mode == 3'd0 && dis && !psw && !dsw, "R1", "por hold",
          pack_out(mode, dsw, lim, dis, psw), pack_out(3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    por = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      logic [10:0] e;
      logic [6:0] exp_o;
      e    = VEC[v];
      ctl  = e[10:8];
      ilim = e[7];
      hid  = e[6];
      settle(SETTLE, seen);
      exp_o = pack_out(e[5:3], e[2], e[1], 1'b0, e[5:3] != 3'd0);
      check(pack_out(mode, dsw, lim, 1'b0, psw) == exp_o && seen == e[0],
            $sformatf("R2/R3 vec%0d", v), "mode,data,ilim,-,pwr|seen",
            {pack_out(mode, dsw, lim, 1'b0, psw), 1'b0, seen},
            {exp_o, 1'b0, e[0]});
    end

    // R3: exact discharge window length, CDP -> shorted
    ctl = 3'b111; ilim = 1'b1;
    settle(SETTLE, seen);
    ctl = 3'b100; ilim = 1'b0;
    hi = 0;
    for (int i = 0; i < SETTLE; i++) begin
      @(negedge clk);
      if (dis && mode == 3'd0) hi++;
    end
    check(hi >= 4*DISCH-3 && hi <= 4*DISCH, "R3", "drain clocks", hi, 4*DISCH);
    check(mode == 3'd2 && psw, "R3", "mode after drain", mode, 2);

    // R9: short glitch ignored
    ctl = 3'b111; ilim = 1'b1;
    repeat (8) @(negedge clk);
    ctl = 3'b100; ilim = 1'b0;
    settle(100, seen);
    check(mode == 3'd2 && !seen, "R9", "glitch mode|seen", {mode, seen}, {3'd2, 1'b0});

    // R10: enable low
    en = 1'b0;
    repeat (4) @(negedge clk);
    check(!psw && dis && !dsw && mode == 3'd0, "R10", "en low",
          pack_out(mode, dsw, lim, dis, psw), pack_out(3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
    settle(60, seen);
    check(!psw && dis, "R10", "en low hold", {psw, dis}, 2'b01);
    en = 1'b1;
    inwin = 1'b0;
    hi = 0;
    for (int i = 0; i < SETTLE; i++) begin
      @(negedge clk);
      if (dis) hi++;
    end
    check(hi >= 4*DISCH-3 && mode == 3'd2 && psw, "R10", "en return drain",
          hi, 4*DISCH);

    // R1: POR during operation
    por = 1'b1;
    repeat (2) @(negedge clk);
    check(mode == 3'd0 && dis && !psw, "R1", "por mid-run", {mode, dis, psw}, {3'd0, 2'b10});
    por = 1'b0;
    settle(SETTLE, seen);
    check(mode == 3'd2 && psw && seen && !inwin, "R1", "after por", mode, 2);

    // R6: data switch off in divider mode even with power on
    ctl = 3'b101;
    settle(SETTLE, seen);
    check(mode == 3'd3 && psw && !dsw, "R6", "divider data off", {mode, dsw}, {3'd3, 1'b0});

    finish_run();
  end

endmodule